// File: doc/BRIEF.md
# Mixed-Length Halfword Instruction Fetcher

This block is the front end of a small processor. It reads instruction memory one 16-bit halfword per cycle and hands whole instructions to the decode stage. An instruction is either a single halfword or a pair of halfwords. The first halfword tells which: when it opens a 32-bit instruction, the fetcher reads the second halfword on the very next cycle. It then presents both halves together, with a length flag and the address of the instruction.

Coming out of reset, the fetcher does not fetch code at once. It first reads the 32-bit start address from memory, as two halfwords in little-endian order, and loads it into the program counter. Sequential fetching starts from there. A redirect input from later stages loads a new program counter at any time. It throws away a half-built instruction and any completed instruction still waiting at the output. A one-entry output slot with a valid/ready handshake lets the decode stage stall the fetcher.

Top module: `hw_fetch_unit`

## Requirements
- R1: While reset is held, `dec_valid` is 0 and `imem_addr` is 0x4.
- R2: After reset, the fetcher reads address 0x4 (low half) and then 0x6 (high half) on consecutive cycles. The first instruction it delivers is at that 32-bit value with bit 0 forced to 0.
- R3: A halfword whose bits 15:11 equal 11101, 11110 or 11111 opens a 32-bit instruction and gives `dec_wide`=1. Every other halfword is a complete 16-bit instruction and gives `dec_wide`=0.
- R4: For a 16-bit instruction, `dec_instr[31:16]` is zero and `dec_instr[15:0]` is the halfword.
- R5: For a 32-bit instruction, the first halfword sits in `dec_instr[31:16]` and the second in `dec_instr[15:0]`. The second halfword is read from the address 2 above the first, in the cycle straight after the first.
- R6: Without a redirect, each delivered instruction's `dec_pc` equals the previous one's `dec_pc` plus 2 (16-bit) or plus 4 (32-bit).
- R7: While `dec_valid`=1 and `dec_ready`=0 with no redirect, the output keeps `dec_valid`, `dec_instr`, `dec_wide` and `dec_pc` unchanged on the next cycle.
- R8: A redirect has priority over everything else. In the cycle after it, `imem_addr` equals `redir_pc` with bit 0 cleared and `dec_valid` is 0. Any half-fetched instruction is dropped, and the next instruction delivered is the one at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | ADDR_W | Byte address of the halfword being read |
| imem_rdata | input | 16 | Halfword returned for `imem_addr` in the same cycle |
| redir_valid | input | 1 | Load a new program counter |
| redir_pc | input | ADDR_W | Redirect target (bit 0 ignored) |
| dec_valid | output | 1 | Output slot holds an instruction |
| dec_ready | input | 1 | Decode stage takes the instruction on this edge |
| dec_instr | output | 32 | Assembled instruction |
| dec_wide | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| dec_pc | output | ADDR_W | Address of the first halfword of the instruction |

## Verification
The bench goes after four corner cases.

- **Boot vector with bit 0 set.** A fetcher that kept that bit would deliver its first instruction at an odd address.
- **Redirect landing while the fetcher waits for the second halfword.** A design that did not drop the partial instruction would deliver a 32-bit word whose halves come from two different places.
- **Long stretches with `dec_ready` low.** A design that kept advancing its PC during the stall would skip instructions or overwrite the held one.
- **Random memory contents of both lengths, with redirects arriving at any point.** These would expose a wrong length decode or a wrong halfword order: both the instruction word and the address sequence would then disagree with the model.

// File: rtl/hwf_pkg.sv
package hwf_pkg;

    localparam int HW_W    = 16;
    localparam int INSTR_W = 2 * HW_W;

    typedef enum logic [1:0] {
        ST_VEC_LO = 2'd0,
        ST_VEC_HI = 2'd1,
        ST_HALF1  = 2'd2,
        ST_HALF2  = 2'd3
    } fetch_state_e;

    // top five bits that mark the opening half of a 32-bit instruction
    localparam logic [4:0] WIDE_TAG_A = 5'b11101;
    localparam logic [4:0] WIDE_TAG_B = 5'b11110;
    localparam logic [4:0] WIDE_TAG_C = 5'b11111;

endpackage

// File: rtl/hwf_len_detect.sv
module hwf_len_detect
    import hwf_pkg::*;
#(
    parameter int W = HW_W
) (
    input  logic [W-1:0] hw,
    output logic         wide
);
    localparam int TAG_LSB = W - 5;

    logic [4:0] tag;

    always_comb begin
        tag  = hw[TAG_LSB +: 5];
        wide = (tag == WIDE_TAG_A) || (tag == WIDE_TAG_B) || (tag == WIDE_TAG_C);
    end
endmodule

// File: rtl/hwf_out_slot.sv
module hwf_out_slot #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              load,
    input  logic              take,
    input  logic [DATA_W-1:0] ld_instr,
    input  logic              ld_wide,
    input  logic [ADDR_W-1:0] ld_pc,
    output logic              valid,
    output logic [DATA_W-1:0] instr,
    output logic              wide,
    output logic [ADDR_W-1:0] pc
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] instr;
        logic              wide;
        logic [ADDR_W-1:0] pc;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.valid = 1'b0;
        end else if (load) begin
            s_d.valid = 1'b1;
            s_d.instr = ld_instr;
            s_d.wide  = ld_wide;
            s_d.pc    = ld_pc;
        end else if (take) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = s_q.valid;
    assign instr = s_q.instr;
    assign wide  = s_q.wide;
    assign pc    = s_q.pc;
endmodule

// File: rtl/hw_fetch_unit.sv
module hw_fetch_unit
    import hwf_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] VEC_ADDR = 32'h0000_0004
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  imem_addr,
    input  logic [HW_W-1:0]    imem_rdata,
    input  logic               redir_valid,
    input  logic [ADDR_W-1:0]  redir_pc,
    output logic               dec_valid,
    input  logic               dec_ready,
    output logic [INSTR_W-1:0] dec_instr,
    output logic               dec_wide,
    output logic [ADDR_W-1:0]  dec_pc
);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(HW_W / 8);
    localparam logic [ADDR_W-1:0] VEC_LO_A = ADDR_W'(VEC_ADDR);
    localparam logic [ADDR_W-1:0] VEC_HI_A = ADDR_W'(VEC_ADDR) + STEP;
    localparam logic [ADDR_W-1:0] ALIGN_M  = ~ADDR_W'(1);

    typedef struct packed {
        fetch_state_e      state;
        logic [ADDR_W-1:0] pc;
        logic [HW_W-1:0]   vec_lo;
        logic [HW_W-1:0]   first_hw;
        logic [ADDR_W-1:0] first_pc;
    } fetch_regs_t;

    fetch_regs_t r_d, r_q;

    logic               rdata_wide;
    logic               slot_free;
    logic               slot_load;
    logic [INSTR_W-1:0] ld_instr;
    logic               ld_wide;
    logic [ADDR_W-1:0]  ld_pc;
    logic [ADDR_W-1:0]  redir_tgt;
    logic [ADDR_W-1:0]  vec_pc;

    hwf_len_detect #(.W(HW_W)) u_len (
        .hw   (imem_rdata),
        .wide (rdata_wide)
    );

    always_comb begin
        redir_tgt = redir_pc & ALIGN_M;
        vec_pc    = ADDR_W'({imem_rdata, r_q.vec_lo}) & ALIGN_M;
        slot_free = !dec_valid || dec_ready;

        case (r_q.state)
            ST_VEC_LO: imem_addr = VEC_LO_A;
            ST_VEC_HI: imem_addr = VEC_HI_A;
            default:   imem_addr = r_q.pc;
        endcase

        r_d       = r_q;
        slot_load = 1'b0;
        ld_instr  = '0;
        ld_wide   = 1'b0;
        ld_pc     = r_q.pc;

        case (r_q.state)
            ST_VEC_LO: begin
                r_d.vec_lo = imem_rdata;
                r_d.state  = ST_VEC_HI;
            end
            ST_VEC_HI: begin
                r_d.pc    = vec_pc;
                r_d.state = ST_HALF1;
            end
            ST_HALF1: begin
                if (slot_free) begin
                    r_d.pc = r_q.pc + STEP;
                    if (rdata_wide) begin
                        r_d.first_hw = imem_rdata;
                        r_d.first_pc = r_q.pc;
                        r_d.state    = ST_HALF2;
                    end else begin
                        slot_load = 1'b1;
                        ld_instr  = {{HW_W{1'b0}}, imem_rdata};
                        ld_wide   = 1'b0;
                        ld_pc     = r_q.pc;
                    end
                end
            end
            ST_HALF2: begin
                slot_load = 1'b1;
                ld_instr  = {r_q.first_hw, imem_rdata};
                ld_wide   = 1'b1;
                ld_pc     = r_q.first_pc;
                r_d.pc    = r_q.pc + STEP;
                r_d.state = ST_HALF1;
            end
            default: r_d.state = ST_VEC_LO;
        endcase

        if (redir_valid) begin
            r_d.state = ST_HALF1;
            r_d.pc    = redir_tgt;
            slot_load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state    <= ST_VEC_LO;
            r_q.pc       <= '0;
            r_q.vec_lo   <= '0;
            r_q.first_hw <= '0;
            r_q.first_pc <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    hwf_out_slot #(.DATA_W(INSTR_W), .ADDR_W(ADDR_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .flush    (redir_valid),
        .load     (slot_load),
        .take     (dec_valid && dec_ready),
        .ld_instr (ld_instr),
        .ld_wide  (ld_wide),
        .ld_pc    (ld_pc),
        .valid    (dec_valid),
        .instr    (dec_instr),
        .wide     (dec_wide),
        .pc       (dec_pc)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !dec_valid); // R1

    AST_VEC_ORDER: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_VEC_LO && !redir_valid) |=> imem_addr == VEC_HI_A); // R2

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> dec_pc[0] == 1'b0); // R2

    AST_WIDE_TAG: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_wide) |-> (dec_instr[31:29] == 3'b111 && dec_instr[28:27] != 2'b00)); // R3

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_wide) |-> dec_instr[31:16] == '0); // R4

    AST_SECOND_HALF_NEXT: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_HALF2 && !redir_valid) |=> (dec_valid && dec_wide)); // R5

    AST_SECOND_HALF_ADDR: assert property (@(posedge clk) disable iff (rst)
        r_q.state == ST_HALF2 |-> imem_addr == r_q.first_pc + STEP); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready && !redir_valid) |=>
            (dec_valid && $stable(dec_instr) && $stable(dec_pc) && $stable(dec_wide))); // R7

    AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (imem_addr == $past(redir_tgt) && !dec_valid)); // R8
endmodule

// File: tb/hw_fetch_unit_tb.sv
module hw_fetch_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] imem_addr;
    logic [15:0] imem_rdata;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic        dec_valid;
    logic        dec_ready;
    logic [31:0] dec_instr;
    logic        dec_wide;
    logic [31:0] dec_pc;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [1024];

    always #2 clk = ~clk;

    assign imem_rdata = mem[imem_addr[10:1]];

    hw_fetch_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .redir_valid (redir_valid),
        .redir_pc    (redir_pc),
        .dec_valid   (dec_valid),
        .dec_ready   (dec_ready),
        .dec_instr   (dec_instr),
        .dec_wide    (dec_wide),
        .dec_pc      (dec_pc)
    );

    // reference model state
    logic [31:0] model_pc;
    bit          first_xfer;
    bit          prev_hold;
    logic [31:0] prev_instr;
    logic [31:0] prev_pc;
    bit          prev_redir;
    logic [31:0] prev_tgt;
    int          idle;

    function automatic bit is_wide(input logic [15:0] h);
        return (h[15:11] == 5'b11101) || (h[15:11] == 5'b11110) || (h[15:11] == 5'b11111);
    endfunction

    function automatic logic [31:0] exp_instr(input logic [31:0] a);
        logic [31:0] a2;
        logic [15:0] h;
        a2 = a + 32'd2;
        h  = mem[a[10:1]];
        if (is_wide(h)) return {h, mem[a2[10:1]]};
        return {16'h0000, h};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // one cycle: sample at negedge, check, drive inputs for the next edge
    task automatic step(input bit rdy, input bit rv, input logic [31:0] tgt);
        logic [31:0] e;
        bit          ew;
        @(negedge clk);
        if (prev_hold) begin
            chk(dec_valid == 1'b1, "R7 valid held", 32'(dec_valid), 32'd1);
            chk(dec_instr == prev_instr, "R7 instr held", dec_instr, prev_instr);
            chk(dec_pc == prev_pc, "R7 pc held", dec_pc, prev_pc);
        end
        if (prev_redir) begin
            chk(imem_addr == prev_tgt, "R8 fetch target", imem_addr, prev_tgt);
            chk(dec_valid == 1'b0, "R8 output flushed", 32'(dec_valid), 32'd0);
        end
        dec_ready   = rdy;
        redir_valid = rv;
        redir_pc    = tgt;
        if (dec_valid && dec_ready) begin
            idle = 0;
            e  = exp_instr(model_pc);
            ew = is_wide(mem[model_pc[10:1]]);
            if (first_xfer)
                chk(dec_pc == model_pc, "R2 first pc", dec_pc, model_pc);
            else
                chk(dec_pc == model_pc, "R6 pc sequence", dec_pc, model_pc);
            chk(dec_wide == ew, "R3 length flag", 32'(dec_wide), 32'(ew));
            if (ew) chk(dec_instr == e, "R5 wide word", dec_instr, e);
            else    chk(dec_instr == e, "R4 narrow word", dec_instr, e);
            model_pc   = model_pc + (ew ? 32'd4 : 32'd2);
            first_xfer = 1'b0;
        end else begin
            idle++;
            if (idle > 500) begin
                chk(1'b0, "R6 watchdog no progress", 32'(idle), 32'd0);
                finish_run();
            end
        end
        if (redir_valid) model_pc = redir_pc & ~32'd1;
        prev_hold  = dec_valid && !dec_ready && !redir_valid;
        prev_instr = dec_instr;
        prev_pc    = dec_pc;
        prev_redir = redir_valid;
        prev_tgt   = redir_pc & ~32'd1;
    endtask

    task automatic do_reset();
        logic [31:0] v;
        @(negedge clk);
        rst = 1'b1; dec_ready = 1'b1; redir_valid = 1'b0; redir_pc = '0;
        repeat (3) @(negedge clk);
        chk(dec_valid == 1'b0, "R1 valid in reset", 32'(dec_valid), 32'd0);
        chk(imem_addr == 32'h4, "R1 addr in reset", imem_addr, 32'h4);
        rst = 1'b0;
        v = {mem[3], mem[2]};
        model_pc   = v & ~32'd1;
        first_xfer = 1'b1;
        prev_hold  = 1'b0;
        prev_redir = 1'b0;
        idle       = 0;
        chk(imem_addr == 32'h4, "R2 low vector read", imem_addr, 32'h4);
        step(1'b1, 1'b0, '0);
        chk(imem_addr == 32'h6, "R2 high vector read", imem_addr, 32'h6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6 global watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) mem[i] = {3'b111, 2'(1 + (r[8:1] % 3)), r[19:9]};
            else begin
                mem[i] = r[31:16];
                if (is_wide(mem[i])) mem[i][15] = 1'b0;
            end
        end
        mem[2] = 16'h0041;              // vector 0x41: bit 0 must be dropped
        mem[3] = 16'h0000;
        mem[12'h100 >> 1] = 16'hF000;   // wide opener
        mem[12'h102 >> 1] = 16'h1234;
        mem[12'h200 >> 1] = 16'h4455;   // narrow

        rst = 1'b1; dec_ready = 1'b1; redir_valid = 1'b0; redir_pc = '0;
        do_reset();

        // straight-line fetch with decode always ready
        repeat (40) step(1'b1, 1'b0, '0);

        // long stall then release
        repeat (20) step(1'b0, 1'b0, '0);
        repeat (10) step(1'b1, 1'b0, '0);

        // redirect into a wide opener, then redirect again while its second half is due
        step(1'b1, 1'b1, 32'h100);
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b1, 32'h201);
        repeat (10) step(1'b1, 1'b0, '0);

        // redirect while an instruction waits in a stalled slot
        repeat (5) step(1'b0, 1'b0, '0);
        step(1'b0, 1'b1, 32'h100);
        repeat (10) step(1'b1, 1'b0, '0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[1:0] != 2'b00, (r[9:4] == 6'd0), r[31:21] & 32'h7FF);
        end

        // second boot with an odd vector
        mem[2] = 16'h0181;
        mem[3] = 16'h0000;
        do_reset();
        repeat (5) step(1'b1, 1'b0, '0);
        for (int n = 0; n < 1000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[2:0] != 3'b000, (r[10:5] == 6'd1), r[31:21] & 32'h7FF);
        end

        finish_run();
    end
endmodule